// File: doc/BRIEF.md
# Parity Memory Self-Test Sequencer

This block drives the port of a byte-wide memory that stores one parity bit beside every byte. Once a run starts, it owns the port. It steps through a fixed list of eleven passes. Each pass first writes a data pattern to every location. It then reads every location back and checks both the byte and its stored parity bit against values it regenerates on its own. The first location that comes back wrong is logged with its address and the kind of pattern that exposed it. The remaining passes still run to the end.

A run starts in one of two ways. It can start by itself on the first clock after reset, so it can serve as a power-on check with no software involved. It can also start from a one-cycle `start` request while the block is idle. At the end of a run the block raises `done` for one cycle. `pass` then reports whether the memory survived, and it holds that value until the next run begins. The memory is expected to have synchronous reads, with the data presented one clock after the read request.

Top module: `mbist_parity`

## Requirements
- R1: While reset is asserted, `busy`, `done`, `pass`, `err_valid` and `mem_en` are all low.
- R2: The passes run in a fixed order. Passes 0 to 7 are walking ones: pass k writes `8'h01 << k` to every address. Pass 8 writes 0xAA to even addresses and 0x55 to odd addresses. Pass 9 writes 0x55 to even addresses and 0xAA to odd addresses. Pass 10 writes pseudo-random data (R5).
- R3: Within a pass, every address is written in ascending order, one per cycle, with `mem_en`=1 and `mem_we`=1. Then every address is read in ascending order, one per cycle, with `mem_en`=1 and `mem_we`=0. Each pass begins in the cycle right after the previous pass ends.
- R4: On every write, `mem_wpar` equals the XOR of the eight data bits, inverted when `ODD_PAR`=1.
- R5: The pseudo-random data comes from an 8-bit register that shifts right. If the bit shifted out is 1, the register is XORed with 0xB8. The register is loaded with `SEED` at the start of both the write sweep and the read sweep, so address i holds the value after i steps.
- R6: Read data and parity arrive one cycle after the read request. A location fails if either the byte or the parity bit differs from the expected value.
- R7: The first failure in a run sets `err_valid` and records `err_addr` and `err_pattern` (0 = walking ones, 1 = checkerboard, 2 = pseudo-random). Later failures in the same run leave the log unchanged.
- R8: `done` is high for exactly one cycle, two cycles after the last read request. During that cycle `pass` is 1 only if no failure was logged, and `pass` keeps its value until the next run starts.
- R9: A `start` pulse while a run is in progress has no effect. A run that begins from idle clears `err_valid` and `pass`.
- R10: With `AUTO_START`=1, a run begins on the first clock edge after reset is released, with no `start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last completed run |
| err_valid | output | 1 | A failure has been logged |
| err_addr | output | ADDR_W | Address of the first failure |
| err_pattern | output | 2 | Pattern kind of the first failure |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Write data byte |
| mem_wpar | output | 1 | Write parity bit |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| mem_rpar | input | 1 | Read parity bit, one cycle after the request |

## Verification
The hardest states to reach are failures that appear only under one pattern kind. Without such failures, the logged pattern code and the rule that only the first failure is kept go untested. The bench memory model therefore has selectable fault modes. One is a stuck data bit that many passes expose. Another corrupts the stored parity only when 0x55 lands on one address, so only the second checkerboard pass sees it. A third corrupts a location only when it receives data that is neither one-hot nor a checkerboard value, so only the pseudo-random pass sees it. A `start` pulse is also injected in the middle of a faulted run to show that neither the sequence nor the log is disturbed.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int BYTE_W   = 8;
  localparam int PASS_W   = 4;
  localparam int NUM_PASS = 11;

  typedef enum logic [1:0] {
    PAT_WALK  = 2'd0,
    PAT_CHECK = 2'd1,
    PAT_PRBS  = 2'd2
  } pat_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_RD, S_FLUSH, S_FIN
  } seq_e;

  // parity bit that makes the byte plus bit even (odd when odd_sel set)
  function automatic logic par_of(input logic [BYTE_W-1:0] d, input logic odd_sel);
    return (^d) ^ odd_sel;
  endfunction

  // one step of the right-shifting Galois generator, feedback mask 0xB8
  function automatic logic [BYTE_W-1:0] prbs_step(input logic [BYTE_W-1:0] s);
    return s[0] ? ((s >> 1) ^ 8'hB8) : (s >> 1);
  endfunction

  function automatic pat_e pass_kind(input logic [PASS_W-1:0] p);
    if (p < 4'd8)       return PAT_WALK;
    else if (p < 4'd10) return PAT_CHECK;
    else                return PAT_PRBS;
  endfunction

  function automatic logic [BYTE_W-1:0] pass_value(input logic [PASS_W-1:0] p,
                                                   input logic a0,
                                                   input logic [BYTE_W-1:0] s);
    if (p < 4'd8)       return 8'd1 << p[2:0];
    else if (p < 4'd10) return (a0 ^ (p == 4'd9)) ? 8'h55 : 8'hAA;
    else                return s;
  endfunction
endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int              ADDR_W     = 4,
  parameter logic [BYTE_W-1:0] SEED     = 8'h5A,
  parameter logic            AUTO_START = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output seq_e              st,
  output logic [PASS_W-1:0] pass_idx,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] prbs,
  output logic              run_go
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASS - 1);

  logic auto_q;
  logic at_end;

  assign at_end = (addr == LAST_ADDR);
  assign run_go = (st == S_IDLE) && (start || auto_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pass_idx <= '0;
      addr     <= '0;
      prbs     <= SEED;
      auto_q   <= AUTO_START;
    end else begin
      case (st)
        S_IDLE: if (run_go) begin
          st       <= S_WR;
          pass_idx <= '0;
          addr     <= '0;
          prbs     <= SEED;
          auto_q   <= 1'b0;
        end
        S_WR: begin
          if (at_end) begin
            st   <= S_RD;
            addr <= '0;
            prbs <= SEED;
          end else begin
            addr <= addr + 1'b1;
            prbs <= prbs_step(prbs);
          end
        end
        S_RD: begin
          if (at_end) begin
            addr <= '0;
            prbs <= SEED;
            if (pass_idx == LAST_PASS) st <= S_FLUSH;
            else begin
              st       <= S_WR;
              pass_idx <= pass_idx + 1'b1;
            end
          end else begin
            addr <= addr + 1'b1;
            prbs <= prbs_step(prbs);
          end
        end
        S_FLUSH: st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
  import mbist_pkg::*;
#(
  parameter int   ADDR_W  = 4,
  parameter logic ODD_PAR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_issue,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_expect,
  input  pat_e              rd_kind,
  input  logic              run_end,
  input  logic [BYTE_W-1:0] rdata,
  input  logic              rpar,
  output logic              mismatch,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [1:0]        err_pattern,
  output logic              pass
);
  logic              chk_v;
  logic [ADDR_W-1:0] chk_addr;
  logic [BYTE_W-1:0] chk_data;
  pat_e              chk_kind;
  logic              ran_q;

  assign mismatch = chk_v && ((rdata != chk_data) || (rpar != par_of(chk_data, ODD_PAR)));
  assign pass     = ran_q && !err_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_v    <= 1'b0;
      chk_addr <= '0;
      chk_data <= '0;
      chk_kind <= PAT_WALK;
    end else begin
      chk_v    <= rd_issue;
      chk_addr <= rd_addr;
      chk_data <= rd_expect;
      chk_kind <= rd_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid   <= 1'b0;
      err_addr    <= '0;
      err_pattern <= '0;
      ran_q       <= 1'b0;
    end else if (clr) begin
      err_valid   <= 1'b0;
      err_addr    <= '0;
      err_pattern <= '0;
      ran_q       <= 1'b0;
    end else begin
      if (mismatch && !err_valid) begin
        err_valid   <= 1'b1;
        err_addr    <= chk_addr;
        err_pattern <= chk_kind;
      end
      if (run_end) ran_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mbist_parity.sv
module mbist_parity
  import mbist_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter logic              ODD_PAR    = 1'b0,
  parameter logic [BYTE_W-1:0] SEED       = 8'h5A,
  parameter logic              AUTO_START = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [1:0]        err_pattern,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_wpar,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_rpar
);
  seq_e              st;
  logic [PASS_W-1:0] pass_idx;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] prbs;
  logic              run_go;
  logic [BYTE_W-1:0] cur_value;
  pat_e              cur_kind;
  logic              mismatch;

  mbist_seq #(.ADDR_W(ADDR_W), .SEED(SEED), .AUTO_START(AUTO_START)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .st(st), .pass_idx(pass_idx),
    .addr(addr), .prbs(prbs), .run_go(run_go)
  );

  assign cur_value = pass_value(pass_idx, addr[0], prbs);
  assign cur_kind  = pass_kind(pass_idx);

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign mem_en    = (st == S_WR) || (st == S_RD);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = addr;
  assign mem_wdata = cur_value;
  assign mem_wpar  = par_of(cur_value, ODD_PAR);

  mbist_cmp #(.ADDR_W(ADDR_W), .ODD_PAR(ODD_PAR)) cmp_i (
    .clk(clk), .rst_n(rst_n), .clr(run_go), .rd_issue(st == S_RD),
    .rd_addr(addr), .rd_expect(cur_value), .rd_kind(cur_kind),
    .run_end(st == S_FLUSH), .rdata(mem_rdata), .rpar(mem_rpar),
    .mismatch(mismatch), .err_valid(err_valid), .err_addr(err_addr),
    .err_pattern(err_pattern), .pass(pass)
  );
endmodule

// File: rtl/mbist_parity_chk.sv
module mbist_parity_chk #(
  parameter int   ADDR_W  = 4,
  parameter logic ODD_PAR = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              err_valid,
  input logic [ADDR_W-1:0] err_addr,
  input logic [1:0]        err_pattern,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_wpar,
  input logic [1:0]        cur_kind,
  input logic              mismatch
);
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
  assert_onehot_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cur_kind == 2'd0) |-> ($countones(mem_wdata) == 1));
  assert_checker_values_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cur_kind == 2'd1) |-> (mem_wdata == 8'hAA || mem_wdata == 8'h55));
  assert_write_is_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);
  assert_ascending_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en) && mem_addr != '0) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
  assert_write_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wpar == ((($countones(mem_wdata) % 2) == 1) ^ ODD_PAR)));
  assert_mismatch_logged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> err_valid);
  assert_log_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && busy) |=> (err_valid && $stable(err_addr) && $stable(err_pattern)));
  assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_pattern != 2'd3));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == !err_valid));
endmodule

bind mbist_parity mbist_parity_chk #(.ADDR_W(ADDR_W), .ODD_PAR(ODD_PAR)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pass(pass),
  .err_valid(err_valid), .err_addr(err_addr), .err_pattern(err_pattern),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_wpar(mem_wpar), .cur_kind(cur_kind), .mismatch(mismatch)
);

// File: tb/mbist_parity_tb_top.sv
`timescale 1ns/1ps
module mbist_parity_tb_top;
  localparam int   AW    = 4;
  localparam int   DEPTH = 1 << AW;
  localparam logic ODDP  = 1'b0;
  localparam int   SEEDV = 'h5A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, pass, err_valid;
  logic [AW-1:0] err_addr;
  logic [1:0]    err_pattern;
  logic          mem_en, mem_we, mem_wpar;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = 8'h00;
  logic          mem_rpar = 1'b0;

  int nchk = 0;
  int nfail = 0;
  int fault_mode = 0;

  logic [7:0] store_d [DEPTH];
  logic       store_p [DEPTH];

  always #4 clk = ~clk;

  mbist_parity #(.ADDR_W(AW), .ODD_PAR(ODDP), .SEED(8'(SEEDV)), .AUTO_START(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
    .err_valid(err_valid), .err_addr(err_addr), .err_pattern(err_pattern),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wpar(mem_wpar), .mem_rdata(mem_rdata), .mem_rpar(mem_rpar)
  );

  function automatic bit even_ones(input logic [7:0] d);
    return ($countones(d) % 2) == 0;
  endfunction

  function automatic logic exp_par(input logic [7:0] d);
    return (even_ones(d) ? 1'b0 : 1'b1) ^ ODDP;
  endfunction

  // memory model with selectable faults
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        logic [7:0] d;
        logic       p;
        d = mem_wdata;
        p = mem_wpar;
        if (fault_mode == 1 && mem_addr == 5) d[3] = 1'b0;
        if (fault_mode == 2 && mem_addr == 6 && mem_wdata == 8'h55) p = ~p;
        if (fault_mode == 3 && mem_addr == 11 && $countones(mem_wdata) > 1 &&
            mem_wdata != 8'hAA && mem_wdata != 8'h55) d[7] = ~d[7];
        store_d[mem_addr] <= d;
        store_p[mem_addr] <= p;
      end else begin
        mem_rdata <= store_d[mem_addr];
        mem_rpar  <= store_p[mem_addr];
      end
    end
  end

  logic [7:0] q_data [$];
  int         q_we [$];
  int         q_addr [$];
  int         q_kind [$];

  task automatic build_ops();
    q_data.delete(); q_we.delete(); q_addr.delete(); q_kind.delete();
    for (int p = 0; p < 11; p++) begin
      for (int w = 1; w >= 0; w--) begin
        int s;
        s = SEEDV;
        for (int a = 0; a < DEPTH; a++) begin
          logic [7:0] v;
          int k;
          if (p < 8) begin
            v = 8'(1 << p); k = 0;
          end else if (p < 10) begin
            k = 1;
            if ((a % 2 == 0) == (p == 8)) v = 8'hAA; else v = 8'h55;
          end else begin
            k = 2; v = 8'(s);
          end
          q_data.push_back(v); q_we.push_back(w); q_addr.push_back(a); q_kind.push_back(k);
          s = (s % 2 == 1) ? ((s / 2) ^ 184) : (s / 2);
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string msg);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic run_check(input bit do_start, input int poke_at, input string runtag);
    bit         e_valid;
    int         e_addr, e_kind;
    e_valid = 0; e_addr = 0; e_kind = 0;
    build_ops();
    if (do_start) begin
      @(negedge clk); start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    for (int i = 0; i < q_we.size(); i++) begin
      @(negedge clk);
      start = (i == poke_at);
      if (q_we[i] == 1) begin
        check(mem_en && mem_we && busy && !done && mem_addr == AW'(q_addr[i]) &&
              mem_wdata == q_data[i] && mem_wpar == exp_par(q_data[i]),
              $sformatf("R2 R3 R4 R5 %s write op %0d: en=%0d we=%0d addr=%0d data=%h par=%0d expected en=1 we=1 addr=%0d data=%h par=%0d",
                        runtag, i, mem_en, mem_we, mem_addr, mem_wdata, mem_wpar,
                        q_addr[i], q_data[i], exp_par(q_data[i])));
      end else begin
        check(mem_en && !mem_we && busy && mem_addr == AW'(q_addr[i]),
              $sformatf("R3 R9 %s read op %0d: en=%0d we=%0d addr=%0d expected en=1 we=0 addr=%0d",
                        runtag, i, mem_en, mem_we, mem_addr, q_addr[i]));
        if (!e_valid && (store_d[q_addr[i]] != q_data[i] ||
                         store_p[q_addr[i]] != exp_par(q_data[i]))) begin
          e_valid = 1; e_addr = q_addr[i]; e_kind = q_kind[i];
        end
      end
    end
    @(negedge clk); start = 1'b0;
    check(!mem_en && busy && !done,
          $sformatf("R8 %s drain cycle: en=%0d busy=%0d done=%0d expected 0 1 0", runtag, mem_en, busy, done));
    @(negedge clk);
    check(done == 1'b1 && pass == !e_valid,
          $sformatf("R8 %s done cycle: done=%0d pass=%0d expected 1 %0d", runtag, done, pass, !e_valid));
    check(err_valid == e_valid && (!e_valid || (err_addr == AW'(e_addr) && err_pattern == 2'(e_kind))),
          $sformatf("R6 R7 %s log: valid=%0d addr=%0d kind=%0d expected %0d %0d %0d",
                    runtag, err_valid, err_addr, err_pattern, e_valid, e_addr, e_kind));
    repeat (3) @(negedge clk);
    check(!done && !busy && !mem_en && pass == !e_valid,
          $sformatf("R8 %s after done: done=%0d busy=%0d en=%0d pass=%0d expected 0 0 0 %0d",
                    runtag, done, busy, mem_en, pass, !e_valid));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !pass && !err_valid && !mem_en,
          $sformatf("R1 reset: busy=%0d done=%0d pass=%0d err=%0d en=%0d expected all 0",
                    busy, done, pass, err_valid, mem_en));
    rst_n = 1'b1;
    // R10: run begins by itself after reset release
    run_check(1'b0, -1, "R10 auto");
    // stuck data bit, with a start pulse mid-run (R9)
    fault_mode = 1;
    run_check(1'b1, 200, "R9 stuck");
    // parity fault only visible under the second checkerboard
    fault_mode = 2;
    run_check(1'b1, -1, "R7 checker");
    // fault only visible under pseudo-random data
    fault_mode = 3;
    run_check(1'b1, -1, "R5 prbs");
    // clean run from idle clears old log
    fault_mode = 0;
    run_check(1'b1, -1, "R9 clear");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule